// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Engine

This block copies data between two memory locations for two independent channels. It shares one simple memory master port between them. Software programs each channel with a source address, a destination address, a 24-bit unit count, a control word and a 7-bit interrupt vector. A shared operation register holds the master enable and the arbitration mode. Each unit is moved as a read, which waits for its acknowledge, followed by a write of the same data, which also waits for its acknowledge.

A unit is 1, 2 or 4 bytes, or a burst of four 32-bit words that counts as four units. The source and the destination each step up, step down or stay fixed. A channel either runs freely or moves one unit at a time while its external request line is high. When its count reaches zero, the channel raises its end flag and stops. If the channel's interrupt enable is set, it also pulses an interrupt carrying its vector.

Register map on `cfg_addr`: 0/1/2/3 are channel 0 source, destination, count and control. 4/5/6/7 are the same four registers for channel 1. 8 is the operation register: bit 0 is the master enable and bit 3 selects round-robin. 9 and 10 are the vectors of channel 0 and channel 1.

Top module: `dma2ch`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low and `irq` is low.
- R2: A channel starts only when the master enable is 1, its control bit 0 (enable) is 1 and its control bit 1 (end flag) is 0. The start is evaluated on a write to either control register, and on an operation-register write that raises the master enable from 0 to 1. Otherwise the channel makes no memory request.
- R3: Control bits 11:10 select the unit: 0 is a byte, 1 is 2 bytes, 2 is 4 bytes, 3 is a burst. `mem_size` is 0, 1 or 2 (byte, half, word) and is never 3.
- R4: Destination mode: bit 14 adds the unit size after each unit, bit 15 subtracts it, and neither bit leaves the address fixed. The source follows bits 12 (add) and 13 (subtract) in the same way.
- R5: In burst mode, one unit is four word read/write pairs at offsets 0, 4, 8 and 12. After the unit, the source always advances by 16, the destination moves by 16 per its mode bits, and the count drops by 4 (down to no less than 0).
- R6: In the other modes, the count drops by 1 per unit. A written count is kept modulo 2^24. When the count reaches 0, the end flag (control bit 1) is set and the channel stops.
- R7: At the end of a channel whose control bit 2 is set, `irq` pulses for one cycle with `irq_vector` equal to that channel's vector. If bit 2 is clear, no pulse occurs.
- R8: When control bit 9 is 0, a unit of channel c starts only while `dreq[c]` is high. When bit 9 is 1, units run back to back.
- R9: A unit's write follows its read. The write data equals the read data, and no new unit starts before the write's acknowledge. A pending request holds its address and direction until acknowledged.
- R10: With both channels ready, operation bit 3 clear always serves channel 0 first. Bit 3 set alternates the channels unit by unit.
- R11: A channel started with a count of 0 sets its end flag at once and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 2 | External request, one per channel |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Completes the current request |
| irq | output | 1 | End-of-transfer interrupt pulse |
| irq_vector | output | VEC_W | Vector of the ending channel |

## Verification
The assertions rely on two assumptions about the environment. First, `mem_ack` is only driven high while `mem_req` is high. Second, a channel's address and count registers are not rewritten while that channel has a transfer running. The bench's memory model only acknowledges a request that is pending, and it does so after a random delay of 0 to 2 cycles. Every channel is programmed only while it is stopped: the bench waits for the end flag before reprogramming, and in the arbitration tests it clears the master enable before programming.

// File: rtl/dma2ch.sv
module dma2ch #(
  parameter int AW    = 32,
  parameter int CNT_W = 24,
  parameter int VEC_W = 7
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [1:0]       dreq,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vector
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [AW-1:0]    sar [2];
  logic [AW-1:0]    dar [2];
  logic [CNT_W-1:0] tcr [2];
  logic [15:0]      ctl [2];
  logic [VEC_W-1:0] vec [2];
  logic             dme, rr_en, cur, last;
  logic [1:0]       active, beat;
  st_t              st;
  logic [31:0]      hold;

  logic [1:0]       sz;
  logic             burst, last_beat;
  logic [AW-1:0]    step, off, sdelta, ddelta;
  logic [CNT_W-1:0] nx_cnt;
  logic [1:0]       elig, go;
  logic             pick, nx_dme, eval_start;
  logic [15:0]      nx_ctl [2];

  assign sz        = ctl[cur][11:10];
  assign burst     = (sz == 2'd3);
  assign last_beat = !burst || (beat == 2'd3);
  assign step      = burst ? AW'(16) : (AW'(1) << sz);
  assign off       = burst ? AW'({beat, 2'b00}) : '0;

  always_comb begin
    ddelta = (ctl[cur][14] ? step : '0) - (ctl[cur][15] ? step : '0);
    sdelta = burst ? AW'(16) : ((ctl[cur][12] ? step : '0) - (ctl[cur][13] ? step : '0));
    if (burst) nx_cnt = (tcr[cur] <= CNT_W'(4)) ? '0 : tcr[cur] - CNT_W'(4);
    else       nx_cnt = tcr[cur] - CNT_W'(1);
  end

  always_comb begin
    for (int c = 0; c < 2; c++)
      elig[c] = active[c] && dme && (ctl[c][9] || dreq[c]);
    if (&elig) pick = rr_en ? ~last : 1'b0;
    else       pick = elig[1] && !elig[0];
  end

  assign nx_dme     = (cfg_we && cfg_addr == 4'd8) ? cfg_wdata[0] : dme;
  assign eval_start = cfg_we && (cfg_addr == 4'd3 || cfg_addr == 4'd7 ||
                                 (cfg_addr == 4'd8 && cfg_wdata[0] && !dme));
  always_comb
    for (int c = 0; c < 2; c++) begin
      nx_ctl[c] = (cfg_we && cfg_addr == 4'(c * 4 + 3)) ? cfg_wdata[15:0] : ctl[c];
      go[c]     = eval_start && nx_dme && nx_ctl[c][0] && !nx_ctl[c][1];
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        sar[c] <= '0; dar[c] <= '0; tcr[c] <= '0; ctl[c] <= '0; vec[c] <= '0;
      end
      dme <= 1'b0; rr_en <= 1'b0; cur <= 1'b0; last <= 1'b0;
      active <= '0; beat <= '0; st <= S_IDLE; hold <= '0;
      irq <= 1'b0; irq_vector <= '0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: if (|elig) begin
          cur <= pick; last <= pick; beat <= '0; st <= S_RD;
        end
        S_RD: if (mem_ack) begin
          hold <= mem_rdata; st <= S_WR;
        end
        S_WR: if (mem_ack) begin
          if (!last_beat) begin
            beat <= beat + 2'd1; st <= S_RD;
          end else begin
            sar[cur] <= sar[cur] + sdelta;
            dar[cur] <= dar[cur] + ddelta;
            tcr[cur] <= nx_cnt;
            st <= S_IDLE;
            if (nx_cnt == '0) begin
              active[cur] <= 1'b0;
              ctl[cur][1] <= 1'b1;
              if (ctl[cur][2]) begin
                irq <= 1'b1; irq_vector <= vec[cur];
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cfg_we) begin
        for (int c = 0; c < 2; c++) begin
          if (cfg_addr == 4'(c * 4))     sar[c] <= AW'(cfg_wdata);
          if (cfg_addr == 4'(c * 4 + 1)) dar[c] <= AW'(cfg_wdata);
          if (cfg_addr == 4'(c * 4 + 2)) tcr[c] <= cfg_wdata[CNT_W-1:0];
          if (cfg_addr == 4'(c * 4 + 3)) begin
            ctl[c] <= cfg_wdata[15:0];
            if (!cfg_wdata[0]) active[c] <= 1'b0;
          end
          if (cfg_addr == 4'(9 + c)) vec[c] <= cfg_wdata[VEC_W-1:0];
        end
        if (cfg_addr == 4'd8) begin
          dme <= cfg_wdata[0]; rr_en <= cfg_wdata[3];
        end
      end
      for (int c = 0; c < 2; c++)
        if (go[c]) begin
          if (tcr[c] == '0) ctl[c] <= nx_ctl[c] | 16'h0002;
          else              active[c] <= 1'b1;
        end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      4'd0: cfg_rdata = 32'(sar[0]);
      4'd1: cfg_rdata = 32'(dar[0]);
      4'd2: cfg_rdata = 32'(tcr[0]);
      4'd3: cfg_rdata = 32'(ctl[0]);
      4'd4: cfg_rdata = 32'(sar[1]);
      4'd5: cfg_rdata = 32'(dar[1]);
      4'd6: cfg_rdata = 32'(tcr[1]);
      4'd7: cfg_rdata = 32'(ctl[1]);
      4'd8: cfg_rdata = {28'd0, rr_en, 2'b00, dme};
      4'd9: cfg_rdata = 32'(vec[0]);
      4'd10: cfg_rdata = 32'(vec[1]);
      default: cfg_rdata = '0;
    endcase
  end

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = ((st == S_WR) ? dar[cur] : sar[cur]) + off;
  assign mem_size  = burst ? 2'd2 : sz;
  assign mem_wdata = hold;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_rd_then_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> mem_req && mem_we);
  p_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> mem_wdata == $past(mem_rdata));
  p_irq_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_ack && mem_we));
  p_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);
  p_no_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dme && st == S_IDLE |=> !mem_req);
endmodule

// File: tb/dma2ch_tb.sv
module dma2ch_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [1:0] dreq = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0] mem_size;
  logic irq;
  logic [6:0] irq_vector;

  always #4 clk = ~clk;

  dma2ch u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq), .irq_vector(irq_vector));

  int n_chk = 0, n_bad = 0, n_txn = 0, irq_cnt = 0, dly = 0, ord_n = 0;
  logic [6:0] irq_last;
  logic [31:0] m_sar [2], m_dar [2], rd_addr [2];
  int m_units [2], m_beat [2], m_sz [2], m_dm [2];
  logic rd_ch;
  int ord [64];

  function automatic logic [31:0] hashf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] stepf(input int sz);
    return (sz == 3) ? 32'd16 : (32'd1 << sz);
  endfunction

  function automatic logic [31:0] dmove(input int mode, input int sz);
    return (mode == 1) ? stepf(sz) : (mode == 2) ? -stepf(sz) : 32'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq) begin irq_cnt++; irq_last = irq_vector; end
    if (!rst_n) begin mem_ack = 0; dly = 0; end
    else if (mem_ack) begin mem_ack = 0; dly = $urandom % 3; end
    else if (mem_req) begin
      if (dly != 0) dly--;
      else begin
        logic [31:0] ea;
        int c;
        mem_ack = 1;
        n_txn++;
        if (!mem_we) begin
          c = (mem_addr[31:28] == 4'h2) ? 1 : 0;
          rd_ch = c[0];
          mem_rdata = hashf(mem_addr);
          rd_addr[c] = mem_addr;
          if (m_beat[c] == 0 && ord_n < 64) begin ord[ord_n] = c; ord_n++; end
          ea = m_sar[c] + ((m_sz[c] == 3) ? 32'(m_beat[c] * 4) : 32'd0);
          chk(mem_addr == ea, (m_sz[c] == 3) ? "R5 src addr" : "R4 src addr", mem_addr, ea);
          chk(mem_size == ((m_sz[c] == 3) ? 2'd2 : 2'(m_sz[c])), "R3 size", 32'(mem_size), 32'(m_sz[c]));
        end else begin
          c = rd_ch;
          ea = m_dar[c] + ((m_sz[c] == 3) ? 32'(m_beat[c] * 4) : 32'd0);
          chk(mem_addr == ea, (m_sz[c] == 3) ? "R5 dst addr" : "R4 dst addr", mem_addr, ea);
          chk(mem_wdata == hashf(rd_addr[c]), "R9 write data", mem_wdata, hashf(rd_addr[c]));
          if (m_sz[c] == 3 && m_beat[c] < 3) m_beat[c]++;
          else begin
            m_beat[c] = 0;
            m_units[c]++;
            m_sar[c] += (m_sz[c] == 3) ? 32'd16 : 32'd0;
            m_dar[c] += dmove(m_dm[c], m_sz[c]);
          end
        end
      end
    end
  end

  int m_sm [2];
  always @(negedge clk)
    if (mem_ack && mem_we && m_beat[rd_ch] == 0 && m_sz[rd_ch] != 3)
      m_sar[rd_ch] += dmove(m_sm[rd_ch], m_sz[rd_ch]);

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a; #1; v = cfg_rdata;
  endtask

  task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] cnt, input logic [15:0] ctl, input logic [6:0] v);
    m_sar[c] = s; m_dar[c] = d; m_units[c] = 0; m_beat[c] = 0;
    m_sz[c] = int'(ctl[11:10]);
    m_dm[c] = ctl[14] ? 1 : ctl[15] ? 2 : 0;
    m_sm[c] = ctl[12] ? 1 : ctl[13] ? 2 : 0;
    wr(4'(c * 4), s); wr(4'(c * 4 + 1), d); wr(4'(c * 4 + 2), cnt); wr(4'(9 + c), 32'(v));
    wr(4'(c * 4 + 3), 32'(ctl));
  endtask

  task automatic wait_te(input int c);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(4'(c * 4 + 3), v);
      if (v[1]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] mkctl(input int dm, input int sm, input int sz,
                                        input bit aut, input bit ie);
    logic [15:0] r;
    r = 16'h0001;
    r[15:14] = (dm == 1) ? 2'b01 : (dm == 2) ? 2'b10 : 2'b00;
    r[13:12] = (sm == 1) ? 2'b01 : (sm == 2) ? 2'b10 : 2'b00;
    r[11:10] = 2'(sz);
    r[9] = aut;
    r[2] = ie;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, t0;
    void'($urandom(32'h1C0FFEE));
    for (int c = 0; c < 2; c++) begin m_beat[c] = 0; m_sz[c] = 0; m_sar[c] = 0; m_dar[c] = 0; m_dm[c] = 0; m_sm[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd3, v); chk(v == 0, "R1 ctl0", v, 0);
    rd(4'd6, v); chk(v == 0, "R1 cnt1", v, 0);
    rd(4'd8, v); chk(v == 0, "R1 op", v, 0);
    chk(!mem_req && !irq, "R1 outputs", {30'd0, mem_req, irq}, 0);

    // R2 no start without master enable, then start on its rising write
    prog(0, 32'h1000_8000, 32'h3000_8000, 3, mkctl(1, 1, 2, 1, 0), 7'd5);
    repeat (20) @(negedge clk);
    chk(n_txn == 0, "R2 master off", n_txn, 0);
    wr(4'd8, 32'h1);
    wait_te(0);
    chk(m_units[0] == 3, "R2 start on enable rise", m_units[0], 3);

    // R2 end flag already set blocks start
    t0 = n_txn;
    prog(0, 32'h1000_9000, 32'h3000_9000, 2, mkctl(1, 1, 0, 1, 0) | 16'h0002, 7'd5);
    repeat (20) @(negedge clk);
    chk(n_txn == t0, "R2 end flag blocks", n_txn, t0);
    rd(4'd2, v); chk(v == 2, "R2 count untouched", v, 2);

    // R11 zero count
    t0 = n_txn;
    prog(1, 32'h2000_8000, 32'h4000_8000, 0, mkctl(1, 1, 0, 1, 0), 7'd9);
    repeat (5) @(negedge clk);
    rd(4'd7, v); chk(v[1] == 1'b1, "R11 zero count end", v, 32'h2);
    chk(n_txn == t0, "R11 no traffic", n_txn, t0);

    // R6 count kept modulo 2^24
    prog(1, 32'h2000_8000, 32'h4000_8000, 32'h0100_0002, mkctl(0, 1, 1, 1, 0), 7'd9);
    wait_te(1);
    chk(m_units[1] == 2, "R6 modulo count units", m_units[1], 2);
    rd(4'd6, v); chk(v == 0, "R6 count zero", v, 0);

    // R8 external request
    t0 = n_txn;
    prog(1, 32'h2000_A000, 32'h4000_A000, 3, mkctl(2, 2, 2, 0, 0), 7'd9);
    repeat (20) @(negedge clk);
    chk(n_txn == t0, "R8 waits for request", n_txn, t0);
    dreq = 2'b10;
    wait_te(1);
    dreq = 2'b00;
    chk(m_units[1] == 3, "R8 units with request", m_units[1], 3);

    // R10 fixed priority
    wr(4'd8, 0);
    prog(0, 32'h1000_8000, 32'h3000_8000, 4, mkctl(1, 1, 2, 1, 0), 7'd1);
    prog(1, 32'h2000_8000, 32'h4000_8000, 4, mkctl(1, 1, 2, 1, 0), 7'd2);
    ord_n = 0;
    wr(4'd8, 32'h1);
    wait_te(0); wait_te(1);
    chk(ord_n == 8, "R10 unit total", ord_n, 8);
    for (int i = 0; i < 4; i++) chk(ord[i] == 0, "R10 fixed order", ord[i], 0);

    // R10 round-robin
    wr(4'd8, 0);
    prog(0, 32'h1000_8000, 32'h3000_8000, 4, mkctl(1, 1, 1, 1, 0), 7'd1);
    prog(1, 32'h2000_8000, 32'h4000_8000, 4, mkctl(1, 1, 1, 1, 0), 7'd2);
    ord_n = 0;
    wr(4'd8, 32'h9);
    wait_te(0); wait_te(1);
    for (int i = 1; i < 8; i++) chk(ord[i] != ord[i-1], "R10 alternation", ord[i], 32'(1 - ord[i-1]));
    wr(4'd8, 32'h0);
    wr(4'd8, 32'h1);

    // R3 R4 R5 R6 R7 randomized transfers
    for (int i = 0; i < 24; i++) begin
      int c, sz, dm, sm, cnt, units, ic;
      bit ie;
      logic [6:0] vv;
      logic [31:0] s, d, es, ed;
      c = $urandom % 2; sz = $urandom % 4; dm = $urandom % 3; sm = $urandom % 3;
      cnt = (sz == 3) ? 4 * (1 + $urandom % 2) : 1 + $urandom % 5;
      ie = 1'($urandom % 2); vv = 7'($urandom % 128);
      units = (sz == 3) ? cnt / 4 : cnt;
      s = (c == 0 ? 32'h1000_8000 : 32'h2000_8000) + 32'(($urandom % 64) * 16);
      d = (c == 0 ? 32'h3000_8000 : 32'h4000_8000) + 32'(($urandom % 64) * 16);
      es = s + 32'(units) * ((sz == 3) ? 32'd16 : dmove(sm, sz));
      ed = d + 32'(units) * dmove(dm, sz);
      ic = irq_cnt;
      prog(c, s, d, 32'(cnt), mkctl(dm, sm, sz, 1, ie), vv);
      wait_te(c);
      chk(m_units[c] == units, (sz == 3) ? "R5 burst units" : "R6 units", m_units[c], units);
      rd(4'(c * 4 + 2), v); chk(v == 0, "R6 final count", v, 0);
      rd(4'(c * 4), v); chk(v == es, (sz == 3) ? "R5 final src" : "R4 final src", v, es);
      rd(4'(c * 4 + 1), v); chk(v == ed, "R4 final dst", v, ed);
      chk(irq_cnt - ic == int'(ie), "R7 irq count", irq_cnt - ic, int'(ie));
      if (ie) chk(irq_last == vv, "R7 vector", 32'(irq_last), 32'(vv));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule